// File: doc/BRIEF.md
# Atomic Offload Dispatch Unit

This unit sits between a core's memory-instruction issue port and two downstream paths: the cache port and a request stream toward a memory link. It looks at every request it receives. If the request is an atomic read-modify-write of a supported kind (compare-and-swap or fetch-add) and its address lies inside a software-configured uncacheable window, the request never touches the cache. Instead it is packed into a two-flit command and sent on the link. Every other request passes through to the cache port combinationally, with its fields unchanged.

Each offloaded command takes a tag from a pool of eight. Memory answers with one acknowledgement flit that carries the tag and a success bit. The unit frees the tag and pulses a completion, carrying that tag and bit, back to the core so the atomic can retire. No data comes back. The window is a pair of registers, a lower bound and an upper bound, written through a small configuration port. The window is inclusive at the lower bound and exclusive at the upper bound.

Top module: `atomic_offload_dispatch`

## Requirements
- R1: After reset the link output is idle, no completion is pulsed, all tags are free, and both window registers are zero, so no request is offloaded.
- R2: A write with `cfg_we` high sets the window's lower bound when `cfg_sel` is 0 and the upper bound when `cfg_sel` is 1. The new value governs routing from the next cycle on.
- R3: A request is offloaded exactly when `req_atomic` is 1, `req_opc` is 0 (compare-and-swap) or 1 (fetch-add), and lower <= `req_addr` < upper. Every other request appears on the cache port in the same cycle, with atomic flag, opcode, address and both operands equal to the input.
- R4: For a cached request, `cache_valid` equals `req_valid` and `req_ready` equals `cache_ready`.
- R5: An offloaded request never raises `cache_valid`, so each accepted request takes exactly one path.
- R6: In the cycle after an offload is accepted, `lnk_valid` rises with the head flit. The head flit holds the opcode in bits [2:0], the tag in bits [10:8] and the address from bit 64 up, with all other bits zero. After the head flit's handshake comes the body flit, with the first operand in bits [63:0] and the second in bits [127:64]. Each flit is held unchanged while `lnk_ready` is low, and `lnk_valid` drops after the body handshake.
- R7: An accepted offload takes the lowest-numbered free tag. That tag is shown on `req_tag` during the accepting cycle.
- R8: When all eight tags are in use, `req_ready` is low for requests that would be offloaded, while cached requests still flow.
- R9: An acknowledgement flit (`ack_valid` high) carries its tag in bits [10:8] and its success bit at bit 16. If that tag is in use, one cycle later `cpl_valid` pulses for one cycle with `cpl_tag` and `cpl_ok` taken from the flit, and the tag becomes free again.
- R10: An acknowledgement whose tag is not in use produces no completion.
- R11: While a command is still being sent on the link, `req_ready` is low for requests that would be offloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 1 | 0 selects lower bound, 1 selects upper bound |
| cfg_wdata | input | AW | Window register write value |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request accepted on the chosen path |
| req_atomic | input | 1 | Request is an atomic read-modify-write |
| req_opc | input | 3 | Operation code |
| req_addr | input | AW | Request address |
| req_opa | input | DW | First operand (expected value or addend) |
| req_opb | input | DW | Second operand (new value) |
| req_tag | output | 3 | Tag assigned to an offload accepted this cycle |
| cache_valid | output | 1 | Cache port request valid |
| cache_ready | input | 1 | Cache port ready |
| cache_atomic | output | 1 | Cache port atomic flag |
| cache_opc | output | 3 | Cache port operation code |
| cache_addr | output | AW | Cache port address |
| cache_opa | output | DW | Cache port first operand |
| cache_opb | output | DW | Cache port second operand |
| lnk_valid | output | 1 | Link request flit valid |
| lnk_ready | input | 1 | Link accepts the flit |
| lnk_flit | output | 128 | Link request flit |
| ack_valid | input | 1 | Acknowledgement flit valid |
| ack_flit | input | 128 | Acknowledgement flit |
| cpl_valid | output | 1 | Completion pulse to the core |
| cpl_tag | output | 3 | Tag of the completed offload |
| cpl_ok | output | 1 | Success bit of the completed offload |

## Verification
Routing onto the cache port, `req_ready` and `req_tag` are combinational, so they are checked one nanosecond after the inputs change, in the same cycle. The head flit is due one clock edge after acceptance, and each later flit is due one edge after the previous flit's handshake. The completion pulse is due one edge after the acknowledgement and is gone one edge after that. Each check is sampled at the falling edge that follows the edge at which the result is due. A window register write is checked by routing a request in the cycle right after the write.

// File: rtl/aod_pkg.sv
`timescale 1ns/1ps
package aod_pkg;
    localparam int FLIT_W     = 128;
    localparam int OPC_W      = 3;
    localparam logic [OPC_W-1:0] OPC_CAS  = 3'd0;
    localparam logic [OPC_W-1:0] OPC_FADD = 3'd1;
    // flit field positions shared with the memory side
    localparam int F_OPC_LSB  = 0;
    localparam int F_TAG_LSB  = 8;
    localparam int F_OK_BIT   = 16;
    localparam int F_ADDR_LSB = 64;
    localparam int F_OPB_LSB  = 64;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HEAD = 2'd1,
        PH_BODY = 2'd2
    } phase_e;
endpackage

// File: rtl/aod_region_match.sv
`timescale 1ns/1ps
module aod_region_match #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    always_comb begin
        hit = (addr >= lo) && (addr < hi);
    end
endmodule

// File: rtl/aod_tag_pool.sv
`timescale 1ns/1ps
module aod_tag_pool #(
    parameter int NTAG = 8,
    parameter int TW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            grab,
    output logic [TW-1:0]   grab_tag,
    input  logic            drop_en,
    input  logic [TW-1:0]   drop_tag,
    output logic            drop_hit,
    output logic [NTAG-1:0] busy
);
    logic [NTAG-1:0] busy_d, busy_q;
    logic            any_free;

    always_comb begin
        any_free = 1'b0;
        grab_tag = '0;
        // scan downward so the lowest free index wins
        for (int i = NTAG - 1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                any_free = 1'b1;
                grab_tag = TW'(i);
            end
        end
        drop_hit = drop_en && busy_q[drop_tag];
        busy_d   = busy_q;
        if (drop_hit) busy_d[drop_tag] = 1'b0;
        if (grab && any_free) busy_d[grab_tag] = 1'b1;
        busy = busy_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end
endmodule

// File: rtl/aod_flit_pack.sv
`timescale 1ns/1ps
module aod_flit_pack
    import aod_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64,
    parameter int TW = 3
) (
    input  phase_e            phase,
    input  logic [OPC_W-1:0]  opc,
    input  logic [TW-1:0]     tag,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     opa,
    input  logic [DW-1:0]     opb,
    output logic [FLIT_W-1:0] flit
);
    // AW and DW must not exceed 64
    always_comb begin
        flit = '0;
        if (phase == PH_HEAD) begin
            flit[F_OPC_LSB +: OPC_W] = opc;
            flit[F_TAG_LSB +: TW]    = tag;
            flit[F_ADDR_LSB +: AW]   = addr;
        end else if (phase == PH_BODY) begin
            flit[0 +: DW]          = opa;
            flit[F_OPB_LSB +: DW]  = opb;
        end
    end
endmodule

// File: rtl/atomic_offload_dispatch.sv
`timescale 1ns/1ps
module atomic_offload_dispatch
    import aod_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 64,
    parameter int NTAG = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic                     cfg_sel,
    input  logic [AW-1:0]            cfg_wdata,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_atomic,
    input  logic [2:0]               req_opc,
    input  logic [AW-1:0]            req_addr,
    input  logic [DW-1:0]            req_opa,
    input  logic [DW-1:0]            req_opb,
    output logic [$clog2(NTAG)-1:0]  req_tag,
    output logic                     cache_valid,
    input  logic                     cache_ready,
    output logic                     cache_atomic,
    output logic [2:0]               cache_opc,
    output logic [AW-1:0]            cache_addr,
    output logic [DW-1:0]            cache_opa,
    output logic [DW-1:0]            cache_opb,
    output logic                     lnk_valid,
    input  logic                     lnk_ready,
    output logic [127:0]             lnk_flit,
    input  logic                     ack_valid,
    input  logic [127:0]             ack_flit,
    output logic                     cpl_valid,
    output logic [$clog2(NTAG)-1:0]  cpl_tag,
    output logic                     cpl_ok
);
    localparam int TW = $clog2(NTAG);

    typedef struct packed {
        phase_e            phase;
        logic [TW-1:0]     tag;
        logic [OPC_W-1:0]  opc;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     opa;
        logic [DW-1:0]     opb;
        logic [AW-1:0]     lo;
        logic [AW-1:0]     hi;
        logic              cpl_v;
        logic [TW-1:0]     cpl_t;
        logic              cpl_s;
    } state_t;

    state_t st_d, st_q;

    logic            in_window;
    logic            offload_kind;
    logic            to_link;
    logic            take;
    logic [TW-1:0]   free_tag;
    logic [TW-1:0]   ack_tag;
    logic            ack_match;
    logic [NTAG-1:0] tag_busy;
    logic            tag_avail;
    phase_e          cur_phase;
    logic            unused_ack;

    aod_region_match #(.AW(AW)) u_region (
        .lo   (st_q.lo),
        .hi   (st_q.hi),
        .addr (req_addr),
        .hit  (in_window)
    );

    aod_tag_pool #(.NTAG(NTAG), .TW(TW)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .grab     (take),
        .grab_tag (free_tag),
        .drop_en  (ack_valid),
        .drop_tag (ack_tag),
        .drop_hit (ack_match),
        .busy     (tag_busy)
    );

    aod_flit_pack #(.AW(AW), .DW(DW), .TW(TW)) u_pack (
        .phase (st_q.phase),
        .opc   (st_q.opc),
        .tag   (st_q.tag),
        .addr  (st_q.addr),
        .opa   (st_q.opa),
        .opb   (st_q.opb),
        .flit  (lnk_flit)
    );

    always_comb begin
        cur_phase    = st_q.phase;
        tag_avail    = ~&tag_busy;
        ack_tag      = ack_flit[F_TAG_LSB +: TW];
        unused_ack   = ^ack_flit;
        offload_kind = req_atomic && ((req_opc == OPC_CAS) || (req_opc == OPC_FADD));
        to_link      = offload_kind && in_window;

        cache_valid  = req_valid && !to_link;
        cache_atomic = req_atomic;
        cache_opc    = req_opc;
        cache_addr   = req_addr;
        cache_opa    = req_opa;
        cache_opb    = req_opb;

        req_ready    = to_link ? ((cur_phase == PH_IDLE) && tag_avail) : cache_ready;
        take         = req_valid && req_ready && to_link;
        req_tag      = free_tag;
        lnk_valid    = (cur_phase != PH_IDLE);

        cpl_valid    = st_q.cpl_v;
        cpl_tag      = st_q.cpl_t;
        cpl_ok       = st_q.cpl_s;

        st_d         = st_q;
        st_d.cpl_v   = ack_match;
        st_d.cpl_t   = ack_tag;
        st_d.cpl_s   = ack_flit[F_OK_BIT];

        if (cfg_we) begin
            if (cfg_sel) st_d.hi = cfg_wdata;
            else         st_d.lo = cfg_wdata;
        end

        unique case (cur_phase)
            PH_IDLE: begin
                if (take) begin
                    st_d.phase = PH_HEAD;
                    st_d.tag   = free_tag;
                    st_d.opc   = req_opc;
                    st_d.addr  = req_addr;
                    st_d.opa   = req_opa;
                    st_d.opb   = req_opb;
                end
            end
            PH_HEAD: if (lnk_ready) st_d.phase = PH_BODY;
            PH_BODY: if (lnk_ready) st_d.phase = PH_IDLE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/aod_checker.sv
`timescale 1ns/1ps
module aod_checker
    import aod_pkg::*;
#(
    parameter int NTAG = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            cache_valid,
    input logic            lnk_valid,
    input logic            lnk_ready,
    input logic [127:0]    lnk_flit,
    input logic            ack_valid,
    input logic            cpl_valid,
    input logic [NTAG-1:0] tag_busy,
    input phase_e          cur_phase
);
    // R4
    cache_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_valid |-> req_valid);

    // R5
    one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_valid && req_ready) |=> !$rose(lnk_valid));

    // R6
    hold_flit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_valid && !lnk_ready) |=> (lnk_valid && $stable(lnk_flit)));

    // R6
    two_flit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_valid && lnk_ready && cur_phase == PH_BODY) |=> !lnk_valid);

    // R8
    pool_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&tag_busy) && req_valid && req_ready) |-> cache_valid);

    // R9
    cpl_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> $past(ack_valid));

    // R11
    busy_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_valid && req_valid && req_ready) |-> cache_valid);
endmodule

bind atomic_offload_dispatch aod_checker #(.NTAG(NTAG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .cache_valid (cache_valid),
    .lnk_valid   (lnk_valid),
    .lnk_ready   (lnk_ready),
    .lnk_flit    (lnk_flit),
    .ack_valid   (ack_valid),
    .cpl_valid   (cpl_valid),
    .tag_busy    (tag_busy),
    .cur_phase   (cur_phase)
);

// File: tb/atomic_offload_dispatch_tb.sv
`timescale 1ns/1ps
module atomic_offload_dispatch_tb;
    localparam int AW = 32, DW = 64, NTAG = 8, TW = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, cfg_we, cfg_sel;
    logic [AW-1:0] cfg_wdata;
    logic req_valid, req_ready, req_atomic;
    logic [2:0] req_opc;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_opa, req_opb;
    logic [TW-1:0] req_tag;
    logic cache_valid, cache_ready, cache_atomic;
    logic [2:0] cache_opc;
    logic [AW-1:0] cache_addr;
    logic [DW-1:0] cache_opa, cache_opb;
    logic lnk_valid, lnk_ready;
    logic [127:0] lnk_flit;
    logic ack_valid;
    logic [127:0] ack_flit;
    logic cpl_valid, cpl_ok;
    logic [TW-1:0] cpl_tag;

    atomic_offload_dispatch #(.AW(AW), .DW(DW), .NTAG(NTAG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_atomic(req_atomic), .req_opc(req_opc),
        .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb), .req_tag(req_tag),
        .cache_valid(cache_valid), .cache_ready(cache_ready), .cache_atomic(cache_atomic),
        .cache_opc(cache_opc), .cache_addr(cache_addr), .cache_opa(cache_opa), .cache_opb(cache_opb),
        .lnk_valid(lnk_valid), .lnk_ready(lnk_ready), .lnk_flit(lnk_flit),
        .ack_valid(ack_valid), .ack_flit(ack_flit),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_ok(cpl_ok)
    );

    int checks = 0;
    int fails  = 0;
    logic [NTAG-1:0] mdl_busy = '0;
    logic [AW-1:0] lo_m = '0;
    logic [AW-1:0] hi_m = '0;

    task automatic ceq(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < NTAG; i++) if (!mdl_busy[i]) return i;
        return -1;
    endfunction

    function automatic logic [127:0] head_of(input logic [2:0] op, input int t, input logic [AW-1:0] a);
        return 128'(op) | (128'(t) << 8) | (128'(a) << 64);
    endfunction

    task automatic cfg_write(input bit sel, input logic [AW-1:0] v);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) hi_m = v; else lo_m = v;
    endtask

    task automatic do_ack(input int t, input bit ok, input bit expect_cpl);
        ack_valid = 1'b1;
        ack_flit  = (128'(t) << 8) | (128'(ok) << 16);
        @(negedge clk);
        ack_valid = 1'b0;
        ack_flit  = '0;
        ceq(expect_cpl ? "R9 completion pulse" : "R10 stray ack ignored", 128'(cpl_valid), 128'(expect_cpl));
        if (expect_cpl) begin
            ceq("R9 completion tag", 128'(cpl_tag), 128'(t));
            ceq("R9 completion success", 128'(cpl_ok), 128'(ok));
            mdl_busy[t] = 1'b0;
        end
        @(negedge clk);
        ceq("R9 pulse lasts one cycle", 128'(cpl_valid), 128'd0);
    endtask

    // starts and ends at a falling edge
    task automatic try_req(input bit atom, input logic [2:0] op, input logic [AW-1:0] a,
                           input logic [DW-1:0] x, input logic [DW-1:0] y, input bit ack_now);
        bit exp_off;
        int t;
        exp_off = atom && (op < 3'd2) && (a >= lo_m) && (a < hi_m);
        req_valid = 1'b1; req_atomic = atom; req_opc = op; req_addr = a; req_opa = x; req_opb = y;
        #1;
        if (!exp_off) begin
            ceq("R3 cached route", 128'(cache_valid), 128'd1);
            ceq("R4 ready follows cache", 128'(req_ready), 128'd1);
            ceq("R3 cache fields", {cache_atomic, cache_opc, cache_addr}, {atom, op, a});
            ceq("R3 cache operands", {cache_opa, cache_opb}, {x, y});
            @(negedge clk);
            req_valid = 1'b0;
        end else begin
            t = lowest_free();
            ceq("R5 offload stays off cache", 128'(cache_valid), 128'd0);
            ceq("R3 offload accepted", 128'(req_ready), 128'd1);
            ceq("R7 lowest free tag", 128'(req_tag), 128'(t));
            @(negedge clk);
            req_valid = 1'b0;
            mdl_busy[t] = 1'b1;
            ceq("R6 head valid", 128'(lnk_valid), 128'd1);
            ceq("R6 head flit", lnk_flit, head_of(op, t, a));
            @(negedge clk);
            ceq("R6 body flit", lnk_flit, {y, x});
            @(negedge clk);
            ceq("R6 link idle after body", 128'(lnk_valid), 128'd0);
            if (ack_now) do_ack(t, a[0], 1'b1);
        end
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] addrs [6];
        logic [127:0] held;
        addrs = '{32'h0FF, 32'h100, 32'h101, 32'h1FF, 32'h200, 32'h201};
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        req_valid = 1'b0; req_atomic = 1'b0; req_opc = '0; req_addr = '0; req_opa = '0; req_opb = '0;
        cache_ready = 1'b1; lnk_ready = 1'b1; ack_valid = 1'b0; ack_flit = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ceq("R1 link idle at reset", 128'(lnk_valid), 128'd0);
        ceq("R1 no completion at reset", 128'(cpl_valid), 128'd0);
        // empty window: CAS goes to the cache
        try_req(1'b1, 3'd0, 32'h0, 64'h1, 64'h2, 1'b1);

        // R2: window becomes effective the cycle after the write
        cfg_write(1'b0, 32'h100);
        cfg_write(1'b1, 32'h200);
        try_req(1'b1, 3'd0, 32'h150, 64'hA, 64'hB, 1'b1);

        // near-exhaustive sweep over edges, kinds and opcodes (R3, R5, R6, R7, R9)
        for (int ai = 0; ai < 6; ai++)
            for (int at = 0; at < 2; at++)
                for (int op = 0; op < 8; op++)
                    try_req(at[0], op[2:0], addrs[ai], 64'(ai * 16 + op), 64'(1000 + ai), 1'b1);

        // R2: move upper bound down
        cfg_write(1'b1, 32'h180);
        try_req(1'b1, 3'd1, 32'h180, 64'h5, 64'h0, 1'b1);
        try_req(1'b1, 3'd1, 32'h17F, 64'h6, 64'h0, 1'b1);

        // R7/R8: exhaust the pool
        for (int k = 0; k < NTAG; k++) try_req(1'b1, 3'd0, 32'h110 + 32'(k), 64'(k), 64'(k + 1), 1'b0);
        req_valid = 1'b1; req_atomic = 1'b1; req_opc = 3'd0; req_addr = 32'h120;
        #1;
        ceq("R8 full pool stalls offload", 128'(req_ready), 128'd0);
        ceq("R8 stalled offload not on cache", 128'(cache_valid), 128'd0);
        req_atomic = 1'b0;
        #1;
        ceq("R8 cached path still flows", 128'(req_ready), 128'd1);
        ceq("R8 cached valid", 128'(cache_valid), 128'd1);
        @(negedge clk);
        req_valid = 1'b0;
        do_ack(3, 1'b1, 1'b1);
        try_req(1'b1, 3'd1, 32'h130, 64'h9, 64'h0, 1'b0);
        for (int k = 0; k < NTAG; k++) do_ack(k, k[0], 1'b1);
        // R10: tag 5 already free
        do_ack(5, 1'b1, 1'b0);

        // R6/R11: link backpressure
        lnk_ready = 1'b0;
        req_valid = 1'b1; req_atomic = 1'b1; req_opc = 3'd0; req_addr = 32'h140;
        req_opa = 64'h11; req_opb = 64'h22;
        #1;
        ceq("R7 tag after drain", 128'(req_tag), 128'd0);
        @(negedge clk);
        req_valid = 1'b0;
        mdl_busy[0] = 1'b1;
        held = lnk_flit;
        ceq("R6 head under backpressure", held, head_of(3'd0, 0, 32'h140));
        for (int k = 0; k < 3; k++) begin
            req_valid = 1'b1; req_addr = 32'h141;
            #1;
            ceq("R11 offload blocked while sending", 128'(req_ready), 128'd0);
            @(negedge clk);
            ceq("R6 head held", {127'd0, lnk_valid} ^ 128'd0, 128'd1);
            ceq("R6 head stable", lnk_flit, held);
        end
        req_valid = 1'b0;
        lnk_ready = 1'b1;
        @(negedge clk);
        ceq("R6 body after release", lnk_flit, {64'h22, 64'h11});
        @(negedge clk);
        ceq("R6 idle after body", 128'(lnk_valid), 128'd0);
        do_ack(0, 1'b0, 1'b1);

        // R4: cache backpressure
        cache_ready = 1'b0;
        req_valid = 1'b1; req_atomic = 1'b0; req_addr = 32'h150;
        #1;
        ceq("R4 ready low with cache stalled", 128'(req_ready), 128'd0);
        ceq("R4 cache valid held", 128'(cache_valid), 128'd1);
        @(negedge clk);
        req_valid = 1'b0;
        cache_ready = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule